// File: doc/BRIEF.md
# Phase Interval Digitizer

This block measures the phase error between a reference clock and a divided feedback clock by counting cycles of a fast sampling clock. Both inputs arrive already synchronised to that sampling clock. A rising edge on either input opens a measurement interval, and the rising edge of the other input closes it. The block then reports three things separately: the number of sampling cycles in the interval, a flag that tells which input led, and an overflow bit. Each result is announced by a one-cycle valid strobe.

In a clock synthesizer the two inputs would be a slow reference, for example 50 kHz, and an oscillator output divided back to the same rate. That gives one measurement per reference period. The downstream control logic uses the magnitude and the sign to choose the next oscillator tuning setting. The counter is 9 bits wide by default and saturates instead of wrapping.

Top module: `phase_interval_digitizer`

## Requirements
- R1: When a reference rising edge is detected first and a feedback rising edge is detected d sampling cycles later, the block reports count_out = d and lead_out = 1.
- R2: When a feedback rising edge is detected first and a reference rising edge is detected d cycles later, the block reports count_out = d and lead_out = 0.
- R3: When both rising edges are detected in the same sampling cycle with no interval open, the block reports count_out = 0, lead_out = 0 and ovf_out = 0.
- R4: The reported count saturates at 2^CNT_W-1 (511 by default). ovf_out is 1 exactly when the reported count equals that value, which means the interval was 511 cycles or longer. Otherwise ovf_out is 0.
- R5: valid_out is high for one cycle, in the cycle after the clock edge that detected the closing edge (or the tie). count_out, lead_out and ovf_out change only together with valid_out and hold their values at all other times.
- R6: While an interval is open, further rising edges of the input that opened it are ignored. The interval stays open and the count keeps running from the first edge.
- R7: While rst_n is low, count_out, lead_out, ovf_out and valid_out are 0, and no interval is open after reset is released.
- R8: A rising edge is an input sampled at 0 on one clock edge and at 1 on the next. A level held high produces only one edge.
- R9: After a result, the next interval opens on the next detected rising edge, and its count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, synchronised to clk |
| fb_in | input | 1 | Divided feedback clock, synchronised to clk |
| count_out | output | CNT_W | Interval length in sampling cycles, saturating |
| lead_out | output | 1 | 1 when the reference edge came first |
| ovf_out | output | 1 | Count reached its saturation value |
| valid_out | output | 1 | One-cycle strobe for a new result |

## Verification
The bench drives gaps of one and two cycles, mid-range gaps with each input leading, and gaps of 510, 511 and 600 cycles. A counter that started at the wrong value would be off by one. A counter that wrapped instead of saturating would report a small count on the longest interval and leave the overflow bit low. Simultaneous edges check that a tie gives zero with the lead flag cleared, rather than opening an interval that never closes. The bench also re-pulses the opening input inside an interval. A design that restarted or closed on that input would report a shorter count or the wrong sign. Back-to-back measurements check that the count resets for each interval and that the outputs hold between strobes.

// File: rtl/phase_interval_digitizer.sv
module phase_interval_digitizer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  output logic [CNT_W-1:0] count_out,
  output logic             lead_out,
  output logic             ovf_out,
  output logic             valid_out
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             ref_q, fb_q;
  logic             run_q, ref_led_q;
  logic [CNT_W-1:0] cnt_q;

  logic ref_rise, fb_rise, open_hit, stop_hit, tie_hit;
  logic [CNT_W-1:0] cnt_nxt;

  assign ref_rise = ref_in & ~ref_q;
  assign fb_rise  = fb_in & ~fb_q;
  assign tie_hit  = ~run_q & ref_rise & fb_rise;
  assign open_hit = ~run_q & (ref_rise ^ fb_rise);
  assign stop_hit = run_q & (ref_led_q ? fb_rise : ref_rise);
  assign cnt_nxt  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= ref_in;
      fb_q  <= fb_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      ref_led_q <= 1'b0;
      cnt_q     <= '0;
    end else if (open_hit) begin
      run_q     <= 1'b1;
      ref_led_q <= ref_rise;
      cnt_q     <= CNT_ONE;
    end else if (stop_hit) begin
      run_q     <= 1'b0;
    end else if (run_q) begin
      cnt_q     <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_out <= '0;
      lead_out  <= 1'b0;
      ovf_out   <= 1'b0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= stop_hit | tie_hit;
      if (stop_hit) begin
        count_out <= cnt_q;
        lead_out  <= ref_led_q;
        ovf_out   <= (cnt_q == CNT_MAX);
      end else if (tie_hit) begin
        count_out <= '0;
        lead_out  <= 1'b0;
        ovf_out   <= 1'b0;
      end
    end
  end

  // R4: overflow is only ever reported together with a saturated count
  a_r4_ovf_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_out |-> (count_out == CNT_MAX));

  // R5: published fields move only alongside the strobe
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> ($stable(count_out) && $stable(lead_out) && $stable(ovf_out)));

  // R1: a reference-led result always spans at least one cycle
  a_r1_lead_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && lead_out) |-> (count_out != '0));

  // R6: an edge of the opening input keeps the interval open
  a_r6_opener_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ref_led_q && !fb_in) |=> run_q);

  // R9: every new interval starts its count from the first cycle
  a_r9_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt_q == CNT_ONE));

endmodule

// File: tb/phase_interval_digitizer_tb.sv
module phase_interval_digitizer_tb_top;
  localparam int W   = 9;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic [W-1:0] count_out;
  logic lead_out, ovf_out, valid_out;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R7";
  bit done = 0;

  always #10 clk = ~clk;

  phase_interval_digitizer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .count_out(count_out), .lead_out(lead_out), .ovf_out(ovf_out),
    .valid_out(valid_out));

  // behavioural model: timestamps of detected edges
  bit m_rp = 0, m_fp = 0, m_open = 0, m_lead = 0;
  int m_start = 0;
  int e_cnt = 0; bit e_lead = 0, e_ovf = 0, e_valid = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rp = 0; m_fp = 0; m_open = 0; m_lead = 0;
      e_cnt = 0; e_lead = 0; e_ovf = 0; e_valid = 0;
    end else begin
      bit re, fe;
      re = ref_in && !m_rp;
      fe = fb_in && !m_fp;
      m_rp = ref_in; m_fp = fb_in;
      e_valid = 0;
      if (!m_open) begin
        if (re && fe) begin
          e_cnt = 0; e_lead = 0; e_ovf = 0; e_valid = 1;
        end else if (re || fe) begin
          m_open = 1; m_lead = re; m_start = cyc;
        end
      end else if (m_lead ? fe : re) begin
        int d;
        d = cyc - m_start;
        e_cnt = (d > MAXC) ? MAXC : d;
        e_ovf = (d >= MAXC);
        e_lead = m_lead;
        e_valid = 1;
        m_open = 0;
      end
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (count_out !== W'(e_cnt) || lead_out !== e_lead ||
          ovf_out !== e_ovf || valid_out !== e_valid) begin
        bad++;
        $display("FAIL %s cyc=%0d actual cnt=%0d lead=%0b ovf=%0b v=%0b expected cnt=%0d lead=%0b ovf=%0b v=%0b",
                 tag, cyc, count_out, lead_out, ovf_out, valid_out, e_cnt, e_lead, e_ovf, e_valid);
      end
    end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // opener rises, closer rises gap cycles later; both low afterwards
  task automatic measure(bit ref_first, int gap, bit repulse);
    if (gap == 0) begin
      ref_in = 1; fb_in = 1;
    end else begin
      if (ref_first) ref_in = 1; else fb_in = 1;
      if (repulse && gap > 4) begin
        wait_n(1);
        if (ref_first) ref_in = 0; else fb_in = 0;
        wait_n(1);
        if (ref_first) ref_in = 1; else fb_in = 1;
        wait_n(gap - 2);
      end else begin
        wait_n(gap);
      end
      if (ref_first) fb_in = 1; else ref_in = 1;
    end
    wait_n(3);
    ref_in = 0; fb_in = 0;
    wait_n(3);
  endtask

  initial begin
    wait_n(3);
    tag = "R7"; // outputs zero during reset
    total++;
    if (count_out !== '0 || lead_out !== 0 || ovf_out !== 0 || valid_out !== 0) begin
      bad++;
      $display("FAIL R7 reset actual cnt=%0d lead=%0b ovf=%0b v=%0b expected all 0",
               count_out, lead_out, ovf_out, valid_out);
    end
    rst_n = 1;
    wait_n(2);
    tag = "R1"; measure(1, 1, 0); measure(1, 2, 0); measure(1, 37, 0);
    tag = "R2"; measure(0, 1, 0); measure(0, 25, 0);
    tag = "R3"; measure(1, 0, 0);
    tag = "R8"; ref_in = 1; wait_n(10); fb_in = 1; wait_n(10); ref_in = 0; fb_in = 0; wait_n(3);
    tag = "R6"; measure(1, 40, 1); measure(0, 30, 1);
    tag = "R4"; measure(1, 510, 0); measure(0, 511, 0); measure(1, 600, 0);
    tag = "R9"; measure(1, 5, 0); measure(0, 3, 0); measure(1, 0, 0); measure(1, 7, 0);
    tag = "R5"; wait_n(20);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    bad++; total++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule